// File: doc/BRIEF.md
# Key-Guarded Configuration Register Pair

This block holds two configuration registers for a flash interface controller. One is a 4-bit interface-control register; the other is a 26-bit timing register. Both sit behind a write key. Software first writes the 16-bit key value to a lock register. That grants exactly one write to either protected register. Once that write is done, the grant is withdrawn automatically.

A protected write made without a grant leaves the register untouched. It raises a one-cycle fault pulse instead. Reads are always free and never spend a grant.

Access is through a simple single-cycle register bus with a combinational read path. The current register contents drive dedicated output pins. The meaning of the timing fields is left to downstream logic.

Top module: `cfgkey_guard`

## Requirements
- R1: After reset both protected registers read 0, every configuration output is 0, `wr_fault` is 0 and the block is locked (address 0 reads 0).
- R2: A write to address 0 whose low 16 data bits equal 0xA25E opens the block; the upper data bits are ignored. Reading address 0 returns the open state in bit 0 and zeros elsewhere.
- R3: A write to address 0 with any other low 16 bits leaves the block locked. This also closes it if it was open.
- R4: While open, a write to address 1 loads data bits [3:0] into the interface-control register, and a write to address 2 loads data bits [25:0] into the timing register. Either write closes the block in the same cycle.
- R5: A write to address 1 or 2 while locked leaves both registers unchanged. It drives `wr_fault` high for exactly the one cycle after the write.
- R6: Reads of any address never change the open state or the registers.
- R7: The interface-control register bits map to outputs as follows: bit 0 to `cfg_bus16`, bit 1 to `cfg_addr5`, bit 2 to `cfg_bigpage`, bit 3 to `cfg_wprot`.
- R8: Address 1 and 2 read back their registers zero-extended. Address 3 reads 0. Writes to address 3 are ignored: they change no register, raise no fault and do not spend a grant.
- R9: A grant spent on the interface-control register does not carry over. A following timing write needs a new key write, or it faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 lock, 1 interface control, 2 timing, 3 unused |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| wr_fault | output | 1 | One-cycle pulse after a refused protected write |
| cfg_bus16 | output | 1 | Interface-control bit 0 |
| cfg_addr5 | output | 1 | Interface-control bit 1 |
| cfg_bigpage | output | 1 | Interface-control bit 2 |
| cfg_wprot | output | 1 | Interface-control bit 3 |
| timing_cfg | output | 26 | Timing register contents |

## Verification
The bench targets the single-use grant. If a grant survived its write, an unkeyed timing update right after an interface-control update would land instead of faulting. It also tests a near-miss key (0xA25F) and a key with garbage in the upper half. A decoder that compared all 32 bits, or that matched too loosely, would open or stay shut at the wrong time. Reads and unused-address writes are interleaved between key and protected write; a design that let them spend the grant would then fault on a legal update. Random traffic with a reference model also catches a fault pulse that is late, stretched, or fired on a granted write.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;
  localparam int KEY_W   = 16;
  localparam logic [KEY_W-1:0] KEY_VAL = 16'hA25E;
  localparam int ICTL_W  = 4;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LOCK = 2'd0,
    SEL_ICTL = 2'd1,
    SEL_TIM  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // key comparison on the low field only
  function automatic logic key_hit(input logic [KEY_W-1:0] low_bits);
    return low_bits == KEY_VAL;
  endfunction

  // next open state given this cycle's events
  function automatic logic next_open(input logic cur, input logic lock_wr,
                                     input logic key_ok, input logic prot_req);
    if (lock_wr)       return key_ok;
    else if (prot_req) return 1'b0;
    else               return cur;
  endfunction
endpackage

// File: rtl/cfgkey_decode.sv
module cfgkey_decode
  import cfgkey_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [KEY_W-1:0]  key_field,
  output logic              lock_wr,
  output logic              key_ok,
  output logic              ictl_req,
  output logic              tim_req
);
  logic wr_any;
  assign wr_any = bus_sel & bus_wr;

  always_comb begin
    lock_wr  = 1'b0;
    ictl_req = 1'b0;
    tim_req  = 1'b0;
    unique case (reg_sel_e'(bus_addr))
      SEL_LOCK: lock_wr  = wr_any;
      SEL_ICTL: ictl_req = wr_any;
      SEL_TIM:  tim_req  = wr_any;
      default:  ;
    endcase
  end

  assign key_ok = key_hit(key_field);
endmodule

// File: rtl/cfgkey_gate.sv
module cfgkey_gate
  import cfgkey_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lock_wr,
  input  logic key_ok,
  input  logic prot_req,
  output logic open_q,
  output logic grant,
  output logic fault_q
);
  logic refuse;

  assign grant  = prot_req & open_q;
  assign refuse = prot_req & ~open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      open_q  <= next_open(open_q, lock_wr, key_ok, prot_req);
      fault_q <= refuse;
    end
  end

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr && key_ok |=> open_q);
  // R3
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr && !key_ok |=> !open_q);
  // R4
  grant_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !open_q);
  // R5
  fault_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> fault_q);
  // R5
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !refuse |=> !fault_q);
  // R6
  open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_wr && !prot_req |=> $stable(open_q));
endmodule

// File: rtl/cfgkey_store.sv
module cfgkey_store #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

  // R5
  no_grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q == $past(d));
endmodule

// File: rtl/cfgkey_guard.sv
module cfgkey_guard
  import cfgkey_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TIM_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wr_fault,
  output logic              cfg_bus16,
  output logic              cfg_addr5,
  output logic              cfg_bigpage,
  output logic              cfg_wprot,
  output logic [TIM_W-1:0]  timing_cfg
);
  logic              lock_wr, key_ok, ictl_req, tim_req, prot_req;
  logic              open_q, grant;
  logic [ICTL_W-1:0] ictl_q;
  logic [TIM_W-1:0]  tim_q;

  cfgkey_decode u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .key_field(bus_wdata[KEY_W-1:0]),
    .lock_wr  (lock_wr),
    .key_ok   (key_ok),
    .ictl_req (ictl_req),
    .tim_req  (tim_req)
  );

  assign prot_req = ictl_req | tim_req;

  cfgkey_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_wr (lock_wr),
    .key_ok  (key_ok),
    .prot_req(prot_req),
    .open_q  (open_q),
    .grant   (grant),
    .fault_q (wr_fault)
  );

  cfgkey_store #(.W(ICTL_W)) u_ictl (
    .clk(clk), .rst_n(rst_n), .we(grant & ictl_req),
    .d(bus_wdata[ICTL_W-1:0]), .q(ictl_q)
  );

  cfgkey_store #(.W(TIM_W)) u_tim (
    .clk(clk), .rst_n(rst_n), .we(grant & tim_req),
    .d(bus_wdata[TIM_W-1:0]), .q(tim_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      unique case (reg_sel_e'(bus_addr))
        SEL_LOCK: bus_rdata = DATA_W'(open_q);
        SEL_ICTL: bus_rdata = DATA_W'(ictl_q);
        SEL_TIM:  bus_rdata = DATA_W'(tim_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign cfg_bus16   = ictl_q[0];
  assign cfg_addr5   = ictl_q[1];
  assign cfg_bigpage = ictl_q[2];
  assign cfg_wprot   = ictl_q[3];
  assign timing_cfg  = tim_q;

  // R9
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant && ictl_req ##1 tim_req && !lock_wr |-> !grant);
  // R8
  spare_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == 2'd3 |=> $stable(open_q) && !wr_fault);
endmodule

// File: tb/cfgkey_guard_tb.sv
`timescale 1ns/1ps
module cfgkey_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wr_fault, cfg_bus16, cfg_addr5, cfg_bigpage, cfg_wprot;
  logic [25:0] timing_cfg;

  int errors = 0, checks = 0;
  bit done = 0;
  bit          m_open = 0;
  logic [3:0]  m_ictl = '0;
  logic [25:0] m_tim = '0;

  cfgkey_guard dut_i (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {31'b0, m_open};
      2'd1: return {28'b0, m_ictl};
      2'd2: return {6'b0, m_tim};
      default: return 32'b0;
    endcase
  endfunction

  // one bus access starting at a falling edge; returns fault seen after it
  task automatic op(input bit w, input logic [1:0] a, input logic [31:0] d, output bit f);
    bit ef;
    logic [31:0] er;
    er = exp_rd(a);
    ef = 0;
    bus_sel = 1; bus_wr = w; bus_addr = a; bus_wdata = d;
    #2;
    if (!w) chk(bus_rdata == er, (a == 0) ? "R2 lock read" : "R8 readback", bus_rdata, er);
    if (w) begin
      case (a)
        2'd0: m_open = (d[15:0] == 16'hA25E);
        2'd1: if (m_open) begin m_ictl = d[3:0];  m_open = 0; end else ef = 1;
        2'd2: if (m_open) begin m_tim  = d[25:0]; m_open = 0; end else ef = 1;
        default: ;
      endcase
    end
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    f = wr_fault;
    chk(wr_fault == ef, "R5 fault", {31'b0, wr_fault}, {31'b0, ef});
    chk({cfg_wprot, cfg_bigpage, cfg_addr5, cfg_bus16} == m_ictl, "R4 ictl", {28'b0, cfg_wprot, cfg_bigpage, cfg_addr5, cfg_bus16}, {28'b0, m_ictl});
    chk(timing_cfg == m_tim, "R4 timing", {6'b0, timing_cfg}, {6'b0, m_tim});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    bit f;
    logic [31:0] r;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_rdata == 0 && wr_fault == 0 && timing_cfg == 0, "R1 reset", {6'b0, timing_cfg}, 0);
    chk({cfg_wprot, cfg_bigpage, cfg_addr5, cfg_bus16} == 0, "R1 reset ictl", {28'b0, cfg_wprot, cfg_bigpage, cfg_addr5, cfg_bus16}, 0);
    rst_n = 1;
    @(negedge clk);
    op(0, 2'd0, 0, f);  // R1 locked
    // R7 bit positions
    op(1, 2'd0, 32'h0000A25E, f);
    op(1, 2'd1, 32'hFFFFFFF6, f);
    chk(cfg_bus16 == 0 && cfg_addr5 == 1 && cfg_bigpage == 1 && cfg_wprot == 0, "R7 bits", {28'b0, cfg_wprot, cfg_bigpage, cfg_addr5, cfg_bus16}, 32'h6);
    // R9 timing needs its own key
    op(1, 2'd2, 32'h3ABCDEF, f);
    chk(f == 1 && timing_cfg == 0, "R9 no carry", {31'b0, f}, 1);
    // R2 upper bits ignored
    op(1, 2'd0, 32'hFFFFA25E, f);
    op(0, 2'd0, 0, f);
    // R6 reads and R8 spare writes do not spend the grant
    op(0, 2'd1, 0, f);
    op(0, 2'd2, 0, f);
    op(1, 2'd3, 32'h12345678, f);
    op(0, 2'd3, 0, f);
    op(0, 2'd0, 0, f);
    op(1, 2'd2, 32'hFFFFFFFF, f);
    chk(f == 0 && timing_cfg == 26'h3FFFFFF, "R6 grant kept", {6'b0, timing_cfg}, 32'h3FFFFFF);
    // R3 near-miss key, and bad key closing an open block
    op(1, 2'd0, 32'h0000A25F, f);
    op(1, 2'd1, 32'h1, f);
    chk(f == 1 && cfg_bus16 == 0, "R3 near key", {31'b0, f}, 1);
    op(1, 2'd0, 32'h0000A25E, f);
    op(1, 2'd0, 32'h00000000, f);
    op(0, 2'd0, 0, f);
    op(1, 2'd1, 32'hF, f);
    chk(f == 1, "R3 reclose", {31'b0, f}, 1);
    // back-to-back refused writes: R5 pulse per write, then quiet
    op(1, 2'd1, 32'hF, f);
    @(negedge clk);
    chk(wr_fault == 0, "R5 pulse end", {31'b0, wr_fault}, 0);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      bit w;
      logic [1:0] a;
      logic [31:0] d;
      w = ($urandom % 3) != 0;
      a = 2'($urandom % 4);
      d = $urandom;
      if (($urandom % 3) == 0) d[15:0] = 16'hA25E;
      if (w && a == 0 && ($urandom % 2) == 0) d[15:0] = 16'hA25E;
      op(w, a, d, f);
    end
    op(0, 2'd0, 0, f);
    r = bus_rdata;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule